// File: doc/BRIEF.md
# Addressed Serial Command Frame Receiver

This block takes a single asynchronous serial line that idles high and turns the stream on it into parsed commands. It first recovers characters from the line. Each character has one start bit, eight data bits and two stop bits. It then groups the characters into fixed-length frames of 28 bytes. A frame opens with a delimiter byte. The second byte carries the destination address, which is compared with a board address strapped on an input. The frame closes with a CRC-8 check byte.

When a frame passes every check, the block presents the instruction byte and the payload bytes on its outputs and raises a strobe for one cycle. The outputs then hold until the next accepted frame. A bad check byte raises a one-cycle CRC error pulse. A bad stop bit raises a one-cycle framing error pulse. A frame that stalls partway through is dropped. The receiver-enable output for the line transceiver stays asserted at all times.

The bit period is set in clock cycles by a parameter. The default is 200 cycles, which gives 4 µs bits from a 50 MHz clock. The payload length, the address width and the stall limit are also parameters.

Top module: `cmd_frame_rx`

## Requirements
- R1: While and after the active-low synchronous reset, `cmd_valid`, `crc_error` and `framing_error` are low and `cmd_instr` and `cmd_payload` are zero. `rx_en` is high whenever reset is released.
- R2: A character is one low start bit, then eight data bits least significant bit first, then two high stop bits, each `CLKS_PER_BIT` cycles long. Each bit is sampled near its middle, after the `rx` line has passed through a two-flop synchronizer.
- R3: A low pulse on `rx` that is already high again at the middle of the start bit is discarded and produces no character.
- R4: A frame is `PAYLOAD_BYTES + 7` bytes long (28 by default), and its byte 0 must be 0x40. While no frame is open, every received byte other than 0x40 is dropped.
- R5: Byte 1 must equal `board_addr` zero-extended to 8 bits. A frame whose byte 1 differs, including a byte that differs only in bits 7:6, produces no `cmd_valid`.
- R6: The last byte must equal the CRC-8 of bytes 0 through 26. The CRC uses polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, processes each byte most significant bit first, and has no final XOR. On a mismatch, `crc_error` pulses for one cycle and `cmd_valid` stays low.
- R7: On an accepted frame, `cmd_valid` is high for exactly one cycle. At the same time `cmd_instr` takes byte 4, and `cmd_payload[8k+7:8k]` takes byte 5+k. Bytes 2, 3 and 26 affect nothing but the CRC. Both outputs change only when `cmd_valid` is high.
- R8: If a frame is open and `GAP_CHARS` × 11 × `CLKS_PER_BIT` cycles pass with no byte received, the partial frame is discarded and the parser hunts for 0x40 again. A shorter idle gap inside a frame does not disturb it.
- R9: A stop bit sampled low produces a one-cycle `framing_error` pulse, discards the character and returns the parser to hunting for a delimiter.
- R10: Frames sent back to back, with no idle beyond the stop bits, are each accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx | input | 1 | Serial data line, idles high |
| board_addr | input | ADDR_W | Board/slot address strap |
| rx_en | output | 1 | Line receiver enable, held high |
| cmd_valid | output | 1 | One-cycle strobe for an accepted frame |
| cmd_instr | output | 8 | Instruction byte of the last accepted frame |
| cmd_payload | output | 8*PAYLOAD_BYTES | Payload of the last accepted frame, byte k at bits 8k+7:8k |
| crc_error | output | 1 | One-cycle pulse on a check byte mismatch |
| framing_error | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The bench targets the cases where the parser's frame position could fall out of step with the line. Frames arrive back to back. A short line glitch comes ahead of a frame. Stray bytes precede a delimiter. A character with a broken stop bit arrives in the middle of a frame. A frame stalls past the idle limit.

A design that did not resynchronise in these cases would swallow the next frame or misalign it, and no strobe would follow. A design that misread the glitch as a start bit would likewise misalign the frame that follows.

The bench also sends an address that differs only in its upper bits, a corrupted check byte, and a frame with an idle gap just under the limit. A design that truncated the address compare would accept the wrong frame. A design with a wrong CRC would flag good frames or pass bad ones. A design with a too-eager timer would drop the legal slow frame.

// File: rtl/cfr_pkg.sv
// Package for the command frame receiver: the delimiter constant,
// the character receiver states and the CRC-8 step function.
package cfr_pkg;

    localparam logic [7:0] FRAME_DELIM = 8'h40;
    localparam logic [7:0] CRC_POLY    = 8'h07;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_START,
        CH_DATA,
        CH_STOP1,
        CH_STOP2
    } ch_state_t;

    // Advances a CRC-8 (poly 0x07, MSB first, no reflection) by one byte.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] data);
        logic [7:0] c;
        c = crc_in ^ data;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/cfr_sync.sv
// Two-flop synchronizer for the asynchronous serial input.
// Assumes the line idles high, so both stages reset to 1.
module cfr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic meta;

    // Shifts the raw input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b1;
            dout <= 1'b1;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end

endmodule

// File: rtl/cfr_char_rx.sv
// Character receiver: 1 start bit, 8 data bits (LSB first), 2 stop bits.
// Waits half a bit after the falling edge to confirm the start bit, then
// samples every CLKS_PER_BIT cycles. Assumes a synchronized input.
// byte_valid and frame_err are single-cycle pulses.
module cfr_char_rx #(
    parameter int CLKS_PER_BIT = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_s,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_err
);
    import cfr_pkg::*;

    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(CLKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_END = CNT_W'(CLKS_PER_BIT - 1);

    ch_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shreg;
    logic             rx_prev;

    // Walks the character state machine and samples at bit centres.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= CH_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            rx_prev    <= 1'b1;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            frame_err  <= 1'b0;
        end else begin
            rx_prev    <= rx_s;
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
            case (state)
                CH_IDLE: begin
                    cnt <= '0;
                    if (rx_prev && !rx_s) state <= CH_START;
                end
                CH_START: begin
                    if (cnt == HALF_END) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= rx_s ? CH_IDLE : CH_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CH_DATA: begin
                    if (cnt == FULL_END) begin
                        cnt   <= '0;
                        shreg <= {rx_s, shreg[7:1]};
                        if (bit_idx == 3'd7) state <= CH_STOP1;
                        bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CH_STOP1: begin
                    if (cnt == FULL_END) begin
                        cnt <= '0;
                        if (rx_s) begin
                            state <= CH_STOP2;
                        end else begin
                            frame_err <= 1'b1;
                            state     <= CH_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CH_STOP2: begin
                    if (cnt == FULL_END) begin
                        cnt   <= '0;
                        state <= CH_IDLE;
                        if (rx_s) begin
                            byte_valid <= 1'b1;
                            byte_data  <= shreg;
                        end else begin
                            frame_err <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= CH_IDLE;
            endcase
        end
    end

    // R9: a character is either delivered or flagged, never both
    a_r9_err_or_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && frame_err));

    // R2: characters are separated by at least a full character time
    a_r2_no_double_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R3: leaving the start check to the data state requires a low line
    a_r3_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DATA && $past(state) == CH_START) |-> !$past(rx_s));

endmodule

// File: rtl/cfr_parser.sv
// Frame parser: hunts for the delimiter, collects the fixed-length frame,
// checks the address and the CRC-8, and publishes instruction and payload
// with a one-cycle strobe. Assumes byte_valid pulses are at least a few
// cycles apart. frame_abort drops any partial frame.
module cfr_parser #(
    parameter int CLKS_PER_BIT  = 200,
    parameter int ADDR_W        = 6,
    parameter int PAYLOAD_BYTES = 21,
    parameter int GAP_CHARS     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_valid,
    input  logic [7:0]                 byte_data,
    input  logic                       frame_abort,
    input  logic [ADDR_W-1:0]          board_addr,
    output logic                       cmd_valid,
    output logic [7:0]                 cmd_instr,
    output logic [8*PAYLOAD_BYTES-1:0] cmd_payload,
    output logic                       crc_error
);
    import cfr_pkg::*;

    localparam int FRAME_BYTES = PAYLOAD_BYTES + 7;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int PIX_W       = (PAYLOAD_BYTES > 1) ? $clog2(PAYLOAD_BYTES) : 1;
    localparam int GAP_LIMIT   = GAP_CHARS * 11 * CLKS_PER_BIT;
    localparam int GAP_W       = $clog2(GAP_LIMIT + 1);
    localparam logic [IDX_W-1:0] IX_ADDR  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IX_INSTR = IDX_W'(4);
    localparam logic [IDX_W-1:0] IX_PAY0  = IDX_W'(5);
    localparam logic [IDX_W-1:0] IX_PAYN  = IDX_W'(5 + PAYLOAD_BYTES - 1);
    localparam logic [IDX_W-1:0] IX_LAST  = IDX_W'(FRAME_BYTES - 1);
    localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(GAP_LIMIT - 1);

    logic [IDX_W-1:0]           idx;
    logic [GAP_W-1:0]           gap;
    logic [7:0]                 crc;
    logic                       addr_ok;
    logic [7:0]                 instr_stage;
    logic [7:0]                 pay_stage [PAYLOAD_BYTES];
    logic [8*PAYLOAD_BYTES-1:0] pay_flat;
    logic [IDX_W-1:0]           pay_off;

    assign pay_off = idx - IX_PAY0;

    // Flattens the staged payload into the output bit order.
    always_comb begin
        for (int k = 0; k < PAYLOAD_BYTES; k++) begin
            pay_flat[8*k +: 8] = pay_stage[k];
        end
    end

    // Tracks frame position, CRC, address match and the stall timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx         <= '0;
            gap         <= '0;
            crc         <= '0;
            addr_ok     <= 1'b0;
            instr_stage <= '0;
            for (int k = 0; k < PAYLOAD_BYTES; k++) pay_stage[k] <= '0;
            cmd_valid   <= 1'b0;
            crc_error   <= 1'b0;
            cmd_instr   <= '0;
            cmd_payload <= '0;
        end else begin
            cmd_valid <= 1'b0;
            crc_error <= 1'b0;
            if (frame_abort) begin
                idx <= '0;
                gap <= '0;
            end else if (byte_valid) begin
                gap <= '0;
                if (idx == '0) begin
                    if (byte_data == FRAME_DELIM) begin
                        idx     <= IDX_W'(1);
                        crc     <= crc8_step(8'h00, byte_data);
                        addr_ok <= 1'b0;
                    end
                end else begin
                    crc <= crc8_step(crc, byte_data);
                    if (idx == IX_ADDR)  addr_ok     <= (byte_data == 8'(board_addr));
                    if (idx == IX_INSTR) instr_stage <= byte_data;
                    if (idx >= IX_PAY0 && idx <= IX_PAYN) pay_stage[PIX_W'(pay_off)] <= byte_data;
                    if (idx == IX_LAST) begin
                        idx <= '0;
                        if (byte_data == crc) begin
                            if (addr_ok) begin
                                cmd_valid   <= 1'b1;
                                cmd_instr   <= instr_stage;
                                cmd_payload <= pay_flat;
                            end
                        end else begin
                            crc_error <= 1'b1;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end else if (idx != '0) begin
                if (gap == GAP_END) begin
                    idx <= '0;
                    gap <= '0;
                end else begin
                    gap <= gap + 1'b1;
                end
            end
        end
    end

    // R6: a frame is never both accepted and flagged
    a_r6_valid_xor_crc: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && crc_error));

    // R7: the strobe lasts a single cycle
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7: published command changes only with the strobe
    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_payload != $past(cmd_payload)) || (cmd_instr != $past(cmd_instr))) |-> cmd_valid);

    // R8: the stall timer never passes its limit
    a_r8_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap < GAP_W'(GAP_LIMIT));

    // R4: frame position stays inside the frame
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IX_LAST);

endmodule

// File: rtl/cmd_frame_rx.sv
// Top of the command frame receiver: synchronizer, character receiver and
// frame parser. Assumes rx is asynchronous and idles high; the line
// receiver enable is kept asserted.
module cmd_frame_rx #(
    parameter int CLKS_PER_BIT  = 200,
    parameter int ADDR_W        = 6,
    parameter int PAYLOAD_BYTES = 21,
    parameter int GAP_CHARS     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx,
    input  logic [ADDR_W-1:0]          board_addr,
    output logic                       rx_en,
    output logic                       cmd_valid,
    output logic [7:0]                 cmd_instr,
    output logic [8*PAYLOAD_BYTES-1:0] cmd_payload,
    output logic                       crc_error,
    output logic                       framing_error
);

    logic       rx_s;
    logic       ch_valid;
    logic [7:0] ch_data;

    assign rx_en = 1'b1;

    cfr_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx),
        .dout (rx_s)
    );

    cfr_char_rx #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_char (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_s      (rx_s),
        .byte_valid(ch_valid),
        .byte_data (ch_data),
        .frame_err (framing_error)
    );

    cfr_parser #(
        .CLKS_PER_BIT (CLKS_PER_BIT),
        .ADDR_W       (ADDR_W),
        .PAYLOAD_BYTES(PAYLOAD_BYTES),
        .GAP_CHARS    (GAP_CHARS)
    ) u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (ch_valid),
        .byte_data  (ch_data),
        .frame_abort(framing_error),
        .board_addr (board_addr),
        .cmd_valid  (cmd_valid),
        .cmd_instr  (cmd_instr),
        .cmd_payload(cmd_payload),
        .crc_error  (crc_error)
    );

endmodule

// File: tb/cmd_frame_rx_test.sv
// Directed bench for cmd_frame_rx with a shortened bit period.
module cmd_frame_rx_test;

    localparam int CPB   = 16;
    localparam int PAYB  = 21;
    localparam int FRB   = PAYB + 7;
    localparam int AW    = 6;
    localparam int GAPC  = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rx = 1'b1;
    logic [AW-1:0]       board_addr = 6'h2A;
    logic                rx_en;
    logic                cmd_valid;
    logic [7:0]          cmd_instr;
    logic [8*PAYB-1:0]   cmd_payload;
    logic                crc_error;
    logic                framing_error;

    int n_cmp = 0;
    int n_bad = 0;
    int n_valid = 0;
    int n_crc = 0;
    int n_ferr = 0;
    logic [7:0] fr [FRB];

    cmd_frame_rx #(
        .CLKS_PER_BIT (CPB),
        .ADDR_W       (AW),
        .PAYLOAD_BYTES(PAYB),
        .GAP_CHARS    (GAPC)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx           (rx),
        .board_addr   (board_addr),
        .rx_en        (rx_en),
        .cmd_valid    (cmd_valid),
        .cmd_instr    (cmd_instr),
        .cmd_payload  (cmd_payload),
        .crc_error    (crc_error),
        .framing_error(framing_error)
    );

    always #10 clk = ~clk;

    // Counts output pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid)     n_valid++;
            if (crc_error)     n_crc++;
            if (framing_error) n_ferr++;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bit-serial reference CRC (poly x^8+x^2+x+1, init 0, MSB first).
    function automatic logic [7:0] ref_crc(input int upto);
        logic [7:0] c;
        logic fb;
        c = 8'h00;
        for (int b = 0; b < upto; b++) begin
            for (int i = 7; i >= 0; i--) begin
                fb = c[7] ^ fr[b][i];
                c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    task automatic build(input logic [7:0] addr_byte, input logic [7:0] instr, input int seed);
        fr[0] = 8'h40;
        fr[1] = addr_byte;
        fr[2] = 8'hC0;
        fr[3] = 8'(seed + 1);
        fr[4] = instr;
        for (int k = 0; k < PAYB; k++) fr[5 + k] = 8'(seed * 7 + k * 13 + 3);
        fr[FRB - 2] = 8'(seed * 5 + 1);
        fr[FRB - 1] = ref_crc(FRB - 1);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_ok);
        rx = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (CPB) @(negedge clk);
        end
        rx = stop_ok;
        repeat (CPB) @(negedge clk);
        rx = 1'b1;
        repeat (CPB) @(negedge clk);
    endtask

    task automatic send_frame(input int gap_after, input int gap_cycles);
        for (int b = 0; b < FRB; b++) begin
            send_byte(fr[b], 1'b1);
            if (b == gap_after) repeat (gap_cycles) @(negedge clk);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic chk_outputs(input string req);
        int errs;
        errs = 0;
        for (int k = 0; k < PAYB; k++) if (cmd_payload[8*k +: 8] !== fr[5 + k]) errs++;
        chk(req, "instr", 32'(cmd_instr), 32'(fr[4]));
        chk(req, "payload bytes wrong", 32'(errs), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", "rx_en", 32'(rx_en), 32'd1);
        chk("R1", "cmd_valid", 32'(cmd_valid), 32'd0);
        chk("R1", "instr", 32'(cmd_instr), 32'd0);
        chk("R1", "payload nonzero", 32'(|cmd_payload), 32'd0);
        chk("R1", "error pulses", 32'({crc_error, framing_error}), 32'd0);
    endtask

    task automatic t_good();
        int v0;
        v0 = n_valid;
        build({2'b00, board_addr}, 8'h06, 1);
        send_frame(-1, 0);
        chk("R2", "valid count", 32'(n_valid - v0), 32'd1);
        chk_outputs("R7");
        chk("R6", "crc errors", 32'(n_crc), 32'd0);
    endtask

    task automatic t_back_to_back();
        int v0;
        v0 = n_valid;
        build({2'b00, board_addr}, 8'h11, 2);
        for (int b = 0; b < FRB; b++) send_byte(fr[b], 1'b1);
        build({2'b00, board_addr}, 8'h22, 3);
        send_frame(-1, 0);
        chk("R10", "valid count", 32'(n_valid - v0), 32'd2);
        chk_outputs("R10");
    endtask

    task automatic t_wrong_addr();
        int v0, c0;
        logic [7:0] prev;
        v0 = n_valid;
        c0 = n_crc;
        prev = cmd_instr;
        build({2'b00, board_addr ^ 6'h01}, 8'h33, 4);
        send_frame(-1, 0);
        build({2'b10, board_addr}, 8'h44, 5);
        send_frame(-1, 0);
        chk("R5", "valid count", 32'(n_valid - v0), 32'd0);
        chk("R5", "crc count", 32'(n_crc - c0), 32'd0);
        chk("R5", "instr held", 32'(cmd_instr), 32'(prev));
    endtask

    task automatic t_bad_crc();
        int v0, c0;
        v0 = n_valid;
        c0 = n_crc;
        build({2'b00, board_addr}, 8'h55, 6);
        fr[FRB - 1] = fr[FRB - 1] ^ 8'h01;
        send_frame(-1, 0);
        chk("R6", "crc pulse", 32'(n_crc - c0), 32'd1);
        chk("R6", "valid count", 32'(n_valid - v0), 32'd0);
    endtask

    task automatic t_glitch();
        int v0;
        v0 = n_valid;
        rx = 1'b0;
        repeat (3) @(negedge clk);
        rx = 1'b1;
        repeat (CPB * 2) @(negedge clk);
        build({2'b00, board_addr}, 8'h66, 7);
        send_frame(-1, 0);
        chk("R3", "valid after glitch", 32'(n_valid - v0), 32'd1);
        chk_outputs("R3");
    endtask

    task automatic t_hunt();
        int v0;
        v0 = n_valid;
        send_byte(8'h11, 1'b1);
        send_byte(8'hC0, 1'b1);
        send_byte(8'h00, 1'b1);
        build({2'b00, board_addr}, 8'h77, 8);
        send_frame(-1, 0);
        chk("R4", "valid after junk", 32'(n_valid - v0), 32'd1);
        chk_outputs("R4");
    endtask

    task automatic t_framing();
        int v0, f0;
        v0 = n_valid;
        f0 = n_ferr;
        build({2'b00, board_addr}, 8'h88, 9);
        for (int b = 0; b < 3; b++) send_byte(fr[b], 1'b1);
        send_byte(8'h5A, 1'b0);
        repeat (CPB) @(negedge clk);
        chk("R9", "framing pulse", 32'(n_ferr - f0), 32'd1);
        build({2'b00, board_addr}, 8'h99, 10);
        send_frame(-1, 0);
        chk("R9", "valid after framing error", 32'(n_valid - v0), 32'd1);
        chk_outputs("R9");
    endtask

    task automatic t_timeout();
        int v0;
        v0 = n_valid;
        build({2'b00, board_addr}, 8'hAA, 11);
        for (int b = 0; b < 10; b++) send_byte(fr[b], 1'b1);
        repeat ((GAPC + 1) * 11 * CPB) @(negedge clk);
        build({2'b00, board_addr}, 8'hBB, 12);
        send_frame(-1, 0);
        chk("R8", "valid after stall", 32'(n_valid - v0), 32'd1);
        chk_outputs("R8");
    endtask

    task automatic t_short_gap();
        int v0;
        v0 = n_valid;
        build({2'b00, board_addr}, 8'hCC, 13);
        send_frame(10, 11 * CPB);
        chk("R8", "valid with short gap", 32'(n_valid - v0), 32'd1);
        chk_outputs("R8");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_good();
        t_back_to_back();
        t_wrong_addr();
        t_bad_crc();
        t_glitch();
        t_hunt();
        t_framing();
        t_timeout();
        t_short_gap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule